// File: doc/BRIEF.md
# Extended-Real Compare and Examine Unit

This unit orders or classifies 80-bit extended-precision floating-point values and turns the outcome into the four condition bits a stack-based floating-point core reports in its status word. It serves four operation kinds: an ordered compare of the stack top against a source, an unordered (quiet) compare, a test of the stack top against positive zero, and an examine that reports the sign and class of the stack top. For compares it also hands a pop count of 0, 1 or 2 to the stack controller.

A caller presents both operands, an empty flag for the stack-top register, the operation kind and the requested pop count, and pulses `start` for one cycle. On the following cycle `valid` is high for one cycle, and the condition bits, the invalid-operation flag and the pop count all change together. They hold until the next result. Operands are read as sign in bit 79, a 15-bit exponent in bits 78:64, and a 64-bit significand in bits 63:0 whose top bit is the explicit integer bit. The "fraction" is significand bits 62:0.

Top module: `fcmp_unit`

## Requirements
- R1: `valid` is high in exactly the cycle after each cycle in which `start` is sampled high, and low in every other cycle.
- R2: Condition bits appear on `cc` as {C3,C2,C1,C0}. With `opSel`=0 (ordered compare), when neither operand is a NaN, stack-top greater than source gives 4'b0000, less gives 4'b0001 and equal gives 4'b1000. Ordering is by value in sign-magnitude form, and neither operand is modified.
- R3: With `opSel`=1 (unordered compare), a NaN in either operand gives 4'b1101 and leaves `invalidOp` low; ordered operands give the same codes as R2.
- R4: `invalidOp` is high with a result exactly when the operation is an ordered compare (`opSel`=0) or a zero test (`opSel`=2) and an operand is a NaN (exponent all ones, fraction non-zero); it is low for every other result.
- R5: With `opSel`=2 the stack top is compared against +0.0 and `srcVal` is ignored: positive gives 4'b0000, negative 4'b0001, either zero 4'b1000, NaN 4'b1101.
- R6: With `opSel`=3 (examine), C1 equals the stack-top sign and {C3,C2,C0} gives the class: NaN 001, normal 010, infinity 011 (exponent all ones, fraction zero), zero 100, denormal 110 (exponent zero, significand non-zero). A non-extreme exponent is reported as normal whatever the integer bit.
- R7: In examine mode a high `stTagEmpty` reports {C3,C2,C0}=101 with C1 the sign, whatever the operand bits; the tag has no effect on other operations.
- R8: `popCount` equals `popReq` for compares when `popReq` is 0, 1 or 2, equals 2 when `popReq` is 3, and is 0 for test and examine.
- R9: +0 and -0 compare equal, and two infinities of the same sign compare equal.
- R10: In cycles without a result, `cc`, `invalidOp` and `popCount` keep their previous values whatever the inputs do.
- R11: While `rstN` is low, `valid`, `cc`, `invalidOp` and `popCount` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation this cycle |
| opSel | input | 2 | 0 ordered compare, 1 unordered compare, 2 zero test, 3 examine |
| popReq | input | 2 | Pops requested by a compare |
| stTagEmpty | input | 1 | Stack-top register is tagged empty |
| stVal | input | 80 | Stack-top operand |
| srcVal | input | 80 | Source operand for compares |
| valid | output | 1 | Result strobe, one cycle after `start` |
| cc | output | 4 | Condition bits {C3,C2,C1,C0} |
| invalidOp | output | 1 | Invalid-operation flag |
| popCount | output | 2 | Pops for the stack controller |

## Verification
The assertions check the strobe timing, that the held outputs do not move without a result, that the pop count never reaches 3 and is zero outside compares, that C1 is clear for non-examine results, and that invalid only comes with the unordered code from an ordered compare or test. The actual ordering of values, the signed-zero and infinity equalities, the class codes and the empty-tag override only show up in the bench's directed and random scenarios, where a behavioural model built from integer keys predicts every field on every cycle.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    OP_ORD   = 2'd0,
    OP_UNORD = 2'd1,
    OP_TEST  = 2'd2,
    OP_EXAM  = 2'd3
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       useZero;
    logic       examine;
    logic       flagNan;
    logic [1:0] popNext;
  } ctlStrobe_t;
endpackage

// File: rtl/fcmp_class.sv
module fcmp_class #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int OPW = 1 + EXP_W + SIG_W
) (
  input  logic [OPW-1:0] val,
  output logic           sign,
  output logic           isNan,
  output logic           isInf,
  output logic           isZero,
  output logic           isDen,
  output logic [OPW-2:0] mag
);
  logic [EXP_W-1:0] expF;
  logic [SIG_W-1:0] sigF;
  logic             expMax, expMin, fracNz;

  assign expF   = val[OPW-2 -: EXP_W];
  assign sigF   = val[SIG_W-1:0];
  assign expMax = &expF;
  assign expMin = ~|expF;
  assign fracNz = |sigF[SIG_W-2:0];

  assign sign   = val[OPW-1];
  assign mag    = val[OPW-2:0];
  assign isNan  = expMax & fracNz;
  assign isInf  = expMax & ~fracNz;
  assign isZero = expMin & ~|sigF;
  assign isDen  = expMin & |sigF;
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  input  logic [1:0] popReq,
  output ctlStrobe_t strobe,
  output logic       valid
);
  opKind_e opK;
  logic    isCmp;

  assign opK   = opKind_e'(opSel);
  assign isCmp = (opK == OP_ORD) || (opK == OP_UNORD);

  always_comb begin
    strobe.load    = start;
    strobe.useZero = (opK == OP_TEST);
    strobe.examine = (opK == OP_EXAM);
    strobe.flagNan = (opK == OP_ORD) || (opK == OP_TEST);
    if (!isCmp)             strobe.popNext = 2'd0;
    else if (popReq == 2'd3) strobe.popNext = 2'd2;
    else                     strobe.popNext = popReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) valid <= 1'b0;
    else       valid <= start;
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int OPW = 1 + EXP_W + SIG_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStrobe_t     strobe,
  input  logic           stTagEmpty,
  input  logic [OPW-1:0] stVal,
  input  logic [OPW-1:0] srcVal,
  output logic [3:0]     cc,
  output logic           invalidOp,
  output logic [1:0]     popCount
);
  localparam int NOPS = 2;

  logic [OPW-1:0] opVal   [NOPS];
  logic           opSign  [NOPS];
  logic           opNan   [NOPS];
  logic           opInf   [NOPS];
  logic           opZero  [NOPS];
  logic           opDen   [NOPS];
  logic [OPW-2:0] opMag   [NOPS];

  assign opVal[0] = stVal;
  assign opVal[1] = strobe.useZero ? '0 : srcVal;

  for (genvar i = 0; i < NOPS; i++) begin : gClass
    fcmp_class #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uClass (
      .val   (opVal[i]),
      .sign  (opSign[i]),
      .isNan (opNan[i]),
      .isInf (opInf[i]),
      .isZero(opZero[i]),
      .isDen (opDen[i]),
      .mag   (opMag[i])
    );
  end

  logic       unordered, magGt, magEq;
  logic [3:0] relCode, examCode, ccNext;
  logic [2:0] cls;
  logic       invNext;

  assign unordered = opNan[0] | opNan[1];
  assign magGt     = opMag[0] > opMag[1];
  assign magEq     = opMag[0] == opMag[1];

  always_comb begin
    if (unordered)
      relCode = 4'b1101;
    else if ((opZero[0] && opZero[1]) || (opSign[0] == opSign[1] && magEq))
      relCode = 4'b1000;
    else if (opSign[0] != opSign[1])
      relCode = opSign[0] ? 4'b0001 : 4'b0000;
    else
      relCode = (magGt ^ opSign[0]) ? 4'b0000 : 4'b0001;
  end

  always_comb begin
    if (stTagEmpty)     cls = 3'b101;
    else if (opNan[0])  cls = 3'b001;
    else if (opInf[0])  cls = 3'b011;
    else if (opZero[0]) cls = 3'b100;
    else if (opDen[0])  cls = 3'b110;
    else                cls = 3'b010;
    examCode = {cls[2], cls[1], opSign[0], cls[0]};
  end

  assign ccNext  = strobe.examine ? examCode : relCode;
  assign invNext = strobe.flagNan & unordered & ~strobe.examine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cc        <= 4'b0000;
      invalidOp <= 1'b0;
      popCount  <= 2'd0;
    end else if (strobe.load) begin
      cc        <= ccNext;
      invalidOp <= invNext;
      popCount  <= strobe.popNext;
    end
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int OPW = 1 + EXP_W + SIG_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [1:0]     opSel,
  input  logic [1:0]     popReq,
  input  logic           stTagEmpty,
  input  logic [OPW-1:0] stVal,
  input  logic [OPW-1:0] srcVal,
  output logic           valid,
  output logic [3:0]     cc,
  output logic           invalidOp,
  output logic [1:0]     popCount
);
  ctlStrobe_t strobe;

  fcmp_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .popReq(popReq),
    .strobe(strobe),
    .valid (valid)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .SIG_W(SIG_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stTagEmpty(stTagEmpty),
    .stVal     (stVal),
    .srcVal    (srcVal),
    .cc        (cc),
    .invalidOp (invalidOp),
    .popCount  (popCount)
  );
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] opSel,
  input logic       valid,
  input logic [3:0] cc,
  input logic       invalidOp,
  input logic [1:0] popCount
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !valid); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(cc) && $stable(invalidOp) && $stable(popCount))); // R10
  AST_POP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    popCount != 2'd3); // R8
  AST_POP_ZERO_NONCMP: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel[1]) |=> popCount == 2'd0); // R8
  AST_C1_CLEAR_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel != 2'd3) |=> !cc[1]); // R2
  AST_INV_ONLY_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    (start && (opSel == 2'd1 || opSel == 2'd3)) |=> !invalidOp); // R4
  AST_INV_WITH_UNORD: assert property (@(posedge clk) disable iff (!rstN)
    (valid && invalidOp) |-> cc == 4'b1101); // R4
endmodule

bind fcmp_unit fcmp_unit_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opSel    (opSel),
  .valid    (valid),
  .cc       (cc),
  .invalidOp(invalidOp),
  .popCount (popCount)
);

// File: tb/fcmp_unit_test.sv
`timescale 1ns/1ps
module fcmp_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [1:0]  popReq = 2'd0;
  logic        stTagEmpty = 1'b0;
  logic [79:0] stVal = '0;
  logic [79:0] srcVal = '0;
  logic        valid;
  logic [3:0]  cc;
  logic        invalidOp;
  logic [1:0]  popCount;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fcmp_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .popReq(popReq),
    .stTagEmpty(stTagEmpty), .stVal(stVal), .srcVal(srcVal),
    .valid(valid), .cc(cc), .invalidOp(invalidOp), .popCount(popCount)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [79:0] mk(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction
  function automatic bit fNan(logic [79:0] x);
    return x[78:64] == 15'h7FFF && x[62:0] != 0;
  endfunction
  function automatic bit fInf(logic [79:0] x);
    return x[78:64] == 15'h7FFF && x[62:0] == 0;
  endfunction
  function automatic bit fZero(logic [79:0] x);
    return x[78:0] == 0;
  endfunction
  // signed ordering key: value sign applied to magnitude, zero -> 0
  function automatic logic signed [81:0] fKey(logic [79:0] x);
    logic signed [81:0] m;
    m = $signed({3'b000, x[78:0]});
    return x[79] ? -m : m;
  endfunction

  logic       mValid = 0;
  logic [3:0] mCc = 0;
  logic       mInv = 0;
  logic [1:0] mPop = 0;
  int         mOp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mCc = 0; mInv = 0; mPop = 0;
    end else begin
      mValid = start;
      if (start) begin
        logic [79:0] b;
        logic signed [81:0] ka, kb;
        mOp = opSel;
        b = (opSel == 2) ? 80'd0 : srcVal;
        if (opSel == 3) begin
          logic [2:0] k;
          if (stTagEmpty) k = 3'b101;
          else if (fNan(stVal)) k = 3'b001;
          else if (fInf(stVal)) k = 3'b011;
          else if (fZero(stVal)) k = 3'b100;
          else if (stVal[78:64] == 0) k = 3'b110;
          else k = 3'b010;
          mCc = {k[2], k[1], stVal[79], k[0]};
          mInv = 0;
          mPop = 0;
        end else begin
          ka = fKey(stVal); kb = fKey(b);
          if (fNan(stVal) || fNan(b)) mCc = 4'b1101;
          else if (ka > kb) mCc = 4'b0000;
          else if (ka < kb) mCc = 4'b0001;
          else mCc = 4'b1000;
          mInv = (opSel != 1) && (fNan(stVal) || fNan(b));
          mPop = (opSel == 2) ? 2'd0 : (popReq == 3 ? 2'd2 : popReq);
        end
      end
    end
  end

  function automatic string ccTag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nChecks++;
      if (valid !== mValid) begin
        nFails++;
        $display("FAIL %s valid: actual %b expected %b", rstN ? "R1" : "R11", valid, mValid);
      end
      if (cc !== mCc) begin
        nFails++;
        $display("FAIL %s cc: actual %b expected %b", !rstN ? "R11" : (mValid ? ccTag(mOp) : "R10"), cc, mCc);
      end
      if (invalidOp !== mInv) begin
        nFails++;
        $display("FAIL %s invalidOp: actual %b expected %b", !rstN ? "R11" : (mValid ? "R4" : "R10"), invalidOp, mInv);
      end
      if (popCount !== mPop) begin
        nFails++;
        $display("FAIL %s popCount: actual %0d expected %0d", !rstN ? "R11" : (mValid ? "R8" : "R10"), popCount, mPop);
      end
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [79:0] P1   = 80'h3FFF_8000_0000_0000_0000; // +1.0
  localparam logic [79:0] P2   = 80'h4000_8000_0000_0000_0000; // +2.0
  localparam logic [79:0] M1   = 80'hBFFF_8000_0000_0000_0000; // -1.0
  localparam logic [79:0] M2   = 80'hC000_8000_0000_0000_0000; // -2.0
  localparam logic [79:0] PZ   = 80'h0;
  localparam logic [79:0] MZ   = 80'h8000_0000_0000_0000_0000;
  localparam logic [79:0] PINF = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] MINF = 80'hFFFF_8000_0000_0000_0000;
  localparam logic [79:0] QNAN = 80'h7FFF_C000_0000_0000_0000;
  localparam logic [79:0] SNAN = 80'hFFFF_8000_0000_0000_0001;
  localparam logic [79:0] PDEN = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] MDEN = 80'h8000_4000_0000_0000_0000;
  localparam logic [79:0] UNRM = 80'h4001_0000_0000_0000_0005; // integer bit clear

  task automatic op(input int o, input int p, input bit e,
                    input logic [79:0] a, input logic [79:0] b);
    @(negedge clk);
    start = 1; opSel = o[1:0]; popReq = p[1:0]; stTagEmpty = e;
    stVal = a; srcVal = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 0;
      opSel = 2'($urandom); popReq = 2'($urandom); stTagEmpty = 1'($urandom);
      stVal = {$urandom, $urandom, 16'($urandom)};
      srcVal = {$urandom, $urandom, 16'($urandom)};
    end
  endtask

  function automatic logic [79:0] rndOperand();
    logic [14:0] e;
    logic [63:0] m;
    case ($urandom % 6)
      0: e = 15'h7FFF;
      1: e = 15'h0;
      2: e = 15'h3FFF;
      default: e = 15'($urandom);
    endcase
    m = {$urandom, $urandom};
    if ($urandom % 4 == 0) m = {1'b1, 63'd0};
    if ($urandom % 8 == 0) m = 64'd0;
    return {1'($urandom), e, m};
  endfunction

  initial begin
    repeat (4) @(negedge clk);           // R11: reset state checked each cycle
    rstN = 1;
    idle(2);
    // R2 ordered compares
    op(0, 0, 0, P2, P1);  op(0, 1, 0, P1, P2);  op(0, 2, 0, P1, P1);
    op(0, 0, 0, M1, M2);  op(0, 0, 0, M2, M1);  op(0, 0, 0, M1, P1);
    op(0, 0, 0, P1, M2);  op(0, 0, 0, PDEN, PZ); op(0, 0, 0, MDEN, M1);
    idle(1);
    // R9 signed zero and infinities
    op(0, 0, 0, PZ, MZ);  op(1, 1, 0, MZ, PZ);  op(0, 0, 0, PINF, PINF);
    op(0, 0, 0, MINF, MINF); op(0, 0, 0, PINF, MINF); op(0, 0, 0, MINF, P1);
    idle(2);
    // R3, R4 NaN handling
    op(0, 0, 0, QNAN, P1); op(0, 0, 0, P1, SNAN); op(1, 2, 0, QNAN, P1);
    op(1, 0, 0, P1, SNAN); op(1, 0, 0, P2, M1);  op(1, 0, 0, M1, M1);
    idle(1);
    // R5 zero test, source ignored
    op(2, 3, 0, P1, QNAN); op(2, 1, 0, M2, PINF); op(2, 0, 0, MZ, M1);
    op(2, 0, 0, QNAN, P1); op(2, 0, 0, MDEN, P1); op(2, 0, 0, PINF, MINF);
    idle(1);
    // R6, R7 examine
    op(3, 2, 0, QNAN, P1); op(3, 0, 0, SNAN, P1); op(3, 0, 0, P1, P1);
    op(3, 0, 0, M2, P1);   op(3, 0, 0, PINF, P1); op(3, 0, 0, MINF, P1);
    op(3, 0, 0, PZ, P1);   op(3, 0, 0, MZ, P1);   op(3, 0, 0, PDEN, P1);
    op(3, 0, 0, MDEN, P1); op(3, 0, 0, UNRM, P1); op(3, 0, 1, P1, P1);
    op(3, 0, 1, MINF, P1); op(0, 0, 1, P2, P1);
    idle(3);
    // R8 pop counts
    for (int p = 0; p < 4; p++) begin
      op(0, p, 0, P1, P2); op(1, p, 0, P2, P1); op(2, p, 0, P1, P1); op(3, p, 0, P1, P1);
    end
    idle(2);
    // random mix with gaps (R1, R10)
    for (int i = 0; i < 600; i++) begin
      op($urandom % 4, $urandom % 4, ($urandom % 5) == 0, rndOperand(),
         ($urandom % 3 == 0) ? rndOperand() : rndOperand());
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    // reset in mid-stream (R11)
    op(0, 2, 0, M1, P1);
    @(negedge clk); start = 0; rstN = 0;
    idle(2);
    @(negedge clk); rstN = 1;
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule